// File: doc/BRIEF.md
# DMA Request Guard with Underrun Detection

This block sits between a converter channel's external conversion trigger and the handshake of a DMA engine. Each accepted trigger raises one DMA request, which stays high until the engine acknowledges it. When the acknowledge arrives, the word on the DMA data bus is loaded into the channel's held-data register. Requests are never queued. At most one is outstanding. If a trigger arrives while a request is still unacknowledged, that trigger is dropped and a sticky underrun flag is set.

While the flag is set, the channel keeps presenting its previously held data. Acknowledges no longer load new words and triggers issue no requests. Software clears the flag by writing a one to it. It recovers the path by dropping DMA enable, which abandons any pending request, and then enabling DMA and triggers again. An interrupt output reports the flag whenever the interrupt enable is set.

Top module: `dma_req_guard`

## Requirements
- R1: When DMA enable is high, no request is pending and the underrun flag is clear, a trigger makes `dma_req_o` high from the next cycle. The request stays high until an acknowledge is taken or DMA enable goes low.
- R2: An acknowledge taken while a request is pending and the flag is clear drops `dma_req_o` in the next cycle. In that same cycle `hold_data_o` takes the value of `dma_data_i`.
- R3: A trigger that arrives while a request is pending, with no acknowledge in the same cycle, sets `udr_flag_o` from the next cycle. `dma_req_o` stays high and no further request is issued.
- R4: While the underrun flag is set, an acknowledge leaves `hold_data_o` unchanged, though it still completes the pending request. Triggers issue no request.
- R5: The flag is write-one-to-clear. A write strobe `flag_wr_i` with `flag_wdata_i`=1 clears the flag from the next cycle. A strobe with `flag_wdata_i`=0 has no effect. If an underrun and a clear happen in the same cycle, the underrun wins.
- R6: `irq_o` is high exactly when the flag is set and `irq_en_i` is high. It is a level and stays high until the flag is cleared or the enable drops.
- R7: While DMA enable is low, any pending request is dropped by the next cycle. In that state triggers produce no request and never set the flag, and acknowledges do not load data.
- R8: An acknowledge and a trigger in the same cycle complete the pending request and issue a fresh request in the next cycle, without setting the flag.
- R9: A synchronous active-high reset makes `dma_req_o`, `udr_flag_o`, `irq_o` and `hold_data_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Conversion trigger pulse |
| dma_en_i | input | 1 | DMA enable |
| dma_ack_i | input | 1 | DMA acknowledge |
| dma_data_i | input | DATA_W | Word delivered by DMA with the acknowledge |
| irq_en_i | input | 1 | Underrun interrupt enable |
| flag_wr_i | input | 1 | Write strobe for the flag bit |
| flag_wdata_i | input | 1 | Written value, 1 clears the flag |
| dma_req_o | output | 1 | DMA request |
| udr_flag_o | output | 1 | Sticky underrun flag |
| irq_o | output | 1 | Underrun interrupt, level |
| hold_data_o | output | DATA_W | Held data presented to the converter |

## Verification
The bench aims at the cycle where an acknowledge and a trigger coincide. A design that checks the trigger before the acknowledge would set a false underrun and lose the new request. It drives an acknowledge after an underrun, where a wrong design would overwrite the held data. It also drives a clear and an underrun in the same cycle, where a wrong priority leaves an underrun unreported. Triggers and acknowledges are also sent while DMA is disabled. A design that ignored the enable there would raise requests, set the flag or load data.

// File: rtl/dma_req_guard_pkg.sv
package dma_req_guard_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } req_state_e;

    typedef struct packed {
        logic start;
        logic take;
        logic clash;
    } hs_evt_t;

    function automatic req_state_e f_next_state(
        input req_state_e cur,
        input logic       enable,
        input hs_evt_t    evt
    );
        if (!enable)        return ST_IDLE;
        else if (evt.start) return ST_PEND;
        else if (evt.take)  return ST_IDLE;
        else                return cur;
    endfunction

endpackage

// File: rtl/dma_req_tracker.sv
module dma_req_tracker
    import dma_req_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    trig,
    input  logic    ack,
    input  logic    enable,
    input  logic    frozen,
    output logic    req,
    output hs_evt_t evt
);
    req_state_e state_q;
    logic       pend;

    assign pend = (state_q == ST_PEND);

    always_comb begin
        evt.take  = enable & ack & pend;
        evt.start = enable & trig & ~frozen & (~pend | ack);
        evt.clash = enable & trig & pend & ~ack;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= f_next_state(state_q, enable, evt);
    end

    assign req = pend;
endmodule

// File: rtl/dma_udr_flag.sv
module dma_udr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)                 flag_q <= 1'b0;
        else if (set)            flag_q <= 1'b1;
        else if (wr && wdata)    flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;
endmodule

// File: rtl/dma_data_hold.sv
module dma_data_hold #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (load) hold_q <= din;
    end

    assign dout = hold_q;
endmodule

// File: rtl/dma_req_guard.sv
module dma_req_guard
    import dma_req_guard_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              dma_en_i,
    input  logic              dma_ack_i,
    input  logic [DATA_W-1:0] dma_data_i,
    input  logic              irq_en_i,
    input  logic              flag_wr_i,
    input  logic              flag_wdata_i,
    output logic              dma_req_o,
    output logic              udr_flag_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] hold_data_o
);
    hs_evt_t evt;
    logic    flag;

    dma_req_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .trig   (trig_i),
        .ack    (dma_ack_i),
        .enable (dma_en_i),
        .frozen (flag),
        .req    (dma_req_o),
        .evt    (evt)
    );

    dma_udr_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (evt.clash),
        .wr     (flag_wr_i),
        .wdata  (flag_wdata_i),
        .irq_en (irq_en_i),
        .flag   (flag),
        .irq    (irq_o)
    );

    dma_data_hold #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (evt.take & ~flag),
        .din  (dma_data_i),
        .dout (hold_data_o)
    );

    assign udr_flag_o = flag;
endmodule

// File: rtl/dma_req_guard_chk.sv
module dma_req_guard_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_i,
    input logic              dma_en_i,
    input logic              dma_ack_i,
    input logic [DATA_W-1:0] dma_data_i,
    input logic              irq_en_i,
    input logic              flag_wr_i,
    input logic              flag_wdata_i,
    input logic              dma_req_o,
    input logic              udr_flag_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] hold_data_o
);
    // R1
    a_r1_req_after_trig: assert property (@(posedge clk) disable iff (rst)
        dma_en_i && trig_i && !dma_req_o && !udr_flag_o |=> dma_req_o);

    // R2
    a_r2_ack_loads: assert property (@(posedge clk) disable iff (rst)
        dma_en_i && dma_req_o && dma_ack_i && !trig_i && !udr_flag_o
        |=> !dma_req_o && hold_data_o == $past(dma_data_i));

    // R3
    a_r3_underrun_set: assert property (@(posedge clk) disable iff (rst)
        dma_en_i && dma_req_o && trig_i && !dma_ack_i |=> udr_flag_o && dma_req_o);

    // R4
    a_r4_frozen_data: assert property (@(posedge clk) disable iff (rst)
        udr_flag_o |=> $stable(hold_data_o));

    // R5
    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
        flag_wr_i && flag_wdata_i && !(dma_en_i && dma_req_o && trig_i && !dma_ack_i)
        |=> !udr_flag_o);

    // R6
    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> udr_flag_o && irq_en_i);

    // R7
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !dma_en_i |=> !dma_req_o && $stable(hold_data_o) && (udr_flag_o -> $past(udr_flag_o)));

    // R8
    a_r8_ack_then_trig: assert property (@(posedge clk) disable iff (rst)
        dma_en_i && dma_req_o && dma_ack_i && trig_i && !udr_flag_o
        |=> dma_req_o && !udr_flag_o);
endmodule

bind dma_req_guard dma_req_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .dma_en_i     (dma_en_i),
    .dma_ack_i    (dma_ack_i),
    .dma_data_i   (dma_data_i),
    .irq_en_i     (irq_en_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .dma_req_o    (dma_req_o),
    .udr_flag_o   (udr_flag_o),
    .irq_o        (irq_o),
    .hold_data_o  (hold_data_o)
);

// File: tb/dma_req_guard_bench.sv
module dma_req_guard_bench;
    localparam int DW = 12;
    localparam int NV = 23;

    typedef struct packed {
        logic          trig, ack, en, ie, wr, wv;
        logic [DW-1:0] d;
        logic          req, flg, irq;
        logic [DW-1:0] q;
        logic [3:0]    rq;
    } vec_t;

    // trig ack en ie wr wv data | req flag irq hold | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h000, 4'd1}, // R1 idle
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0,12'h000, 4'd1}, // R1 request
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0,12'h000, 4'd1}, // R1 held
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,12'h123, 1'b0,1'b0,1'b0,12'h123, 4'd2}, // R2 ack loads
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0,12'h123, 4'd1}, // R1
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,12'h456, 1'b1,1'b0,1'b0,12'h456, 4'd8}, // R8 ack+trig
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b1,1'b1,1'b1,12'h456, 4'd3}, // R3 underrun
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,12'h789, 1'b0,1'b1,1'b1,12'h456, 4'd4}, // R4 no load
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b1,1'b1,12'h456, 4'd4}, // R4 no request
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,12'h000, 1'b0,1'b1,1'b0,12'h456, 4'd6}, // R6 irq masked
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,12'h000, 1'b0,1'b0,1'b0,12'h456, 4'd5}, // R5 clear
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h456, 4'd7}, // R7
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h456, 4'd7}, // R7 trig ignored
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0,12'h456, 4'd1}, // R1
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h456, 4'd7}, // R7 drop pend
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,12'hABC, 1'b0,1'b0,1'b0,12'h456, 4'd7}, // R7 ack ignored
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,12'h000, 1'b1,1'b0,1'b0,12'h456, 4'd1}, // R1
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,12'h000, 1'b1,1'b1,1'b0,12'h456, 4'd6}, // R6 ie low
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,12'h000, 1'b1,1'b1,1'b1,12'h456, 4'd6}, // R6 level
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,12'h000, 1'b1,1'b1,1'b1,12'h456, 4'd5}, // R5 write 0
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,12'h000, 1'b1,1'b1,1'b1,12'h456, 4'd5}, // R5 set wins
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,12'h000, 1'b1,1'b0,1'b0,12'h456, 4'd5}, // R5 clear
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,12'hDEF, 1'b0,1'b0,1'b0,12'hDEF, 4'd2}  // R2
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_i = 1'b0, dma_en_i = 1'b0, dma_ack_i = 1'b0;
    logic [DW-1:0] dma_data_i = '0;
    logic          irq_en_i = 1'b0, flag_wr_i = 1'b0, flag_wdata_i = 1'b0;
    logic          dma_req_o, udr_flag_o, irq_o;
    logic [DW-1:0] hold_data_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_req_guard #(.DATA_W(DW)) u_dma_req_guard (
        .clk(clk), .rst(rst), .trig_i(trig_i), .dma_en_i(dma_en_i),
        .dma_ack_i(dma_ack_i), .dma_data_i(dma_data_i), .irq_en_i(irq_en_i),
        .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .dma_req_o(dma_req_o), .udr_flag_o(udr_flag_o), .irq_o(irq_o),
        .hold_data_o(hold_data_o)
    );

    task automatic check(input int rq, input logic req, input logic flg,
                         input logic irq, input logic [DW-1:0] q);
        checks++;
        if ({dma_req_o, udr_flag_o, irq_o, hold_data_o} !== {req, flg, irq, q}) begin
            errors++;
            $display("FAIL R%0d: req/flag/irq/hold actual %b%b%b %h expected %b%b%b %h",
                     rq, dma_req_o, udr_flag_o, irq_o, hold_data_o, req, flg, irq, q);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        check(9, 1'b0, 1'b0, 1'b0, '0); // R9 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            trig_i = VECS[i].trig; dma_ack_i = VECS[i].ack; dma_en_i = VECS[i].en;
            irq_en_i = VECS[i].ie; flag_wr_i = VECS[i].wr; flag_wdata_i = VECS[i].wv;
            dma_data_i = VECS[i].d;
            step();
            check(int'(VECS[i].rq), VECS[i].req, VECS[i].flg, VECS[i].irq, VECS[i].q);
        end
        // R9: reset in the middle of an underrun
        trig_i = 1'b1; dma_ack_i = 1'b0; dma_en_i = 1'b1; irq_en_i = 1'b1;
        flag_wr_i = 1'b0; flag_wdata_i = 1'b0;
        step(); step();
        check(3, 1'b1, 1'b1, 1'b1, 12'hDEF);
        trig_i = 1'b0; rst = 1'b1;
        step();
        check(9, 1'b0, 1'b0, 1'b0, '0);
        rst = 1'b0;
        // R1 and R2 after reset
        trig_i = 1'b1;
        step();
        check(1, 1'b1, 1'b0, 1'b0, '0);
        trig_i = 1'b0; dma_ack_i = 1'b1; dma_data_i = 12'h5A5;
        step();
        check(2, 1'b0, 1'b0, 1'b0, 12'h5A5);
        dma_ack_i = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule